// File: doc/BRIEF.md
# Video Frame Interrupt Timing Model

This block reproduces, cycle by cycle, how a video controller's once-per-frame interrupt looks to a host processor that shares its clock. A counter advances once per host cycle and wraps at the frame boundary. A few cycles before the wrap it raises a status flag. At the wrap it pulls an active-low interrupt line. The host reads a status port to see the flag and to acknowledge the interrupt. A read that lands shortly before the boundary cancels that frame's interrupt, even when it comes too early to see the flag.

The block also reports whether a video-memory write issued at full host speed would be lost at the current point in the frame. A standard select picks the 50 Hz or 60 Hz frame length. A text-mode select disables the write-loss window. The model is meant for timing-accurate system simulation and emulation cores. In the text below, F is the active frame length and cycle c is the cycle in which the frame counter holds c.

Top module: `frame_irq`

## Requirements
- R1: After reset the counter holds 0, `stat_o` reads 0x00, `irq_no` is high, `wr_fail_o` is low, and the frame length is the 50 Hz value. No interrupt is raised in the first cycle after reset.
- R2: `stat_o[7]` is the frame flag and `stat_o[6:0]` always read 0. The flag becomes visible in cycle F-3 and stays set until a status read clears it.
- R3: Unless a read suppresses it, `irq_no` goes low in cycle 0 of each frame and stays low until the host acknowledges it.
- R4: A status read in cycle t (`stat_rd_i` high) returns the flag as it was before the read, and the flag reads 0 from cycle t+1. If the flag is due to rise in cycle t+1, the rise takes priority over the clear.
- R5: A status read in cycle t while `irq_no` is low makes `irq_no` high from cycle t+3 (latency parameter, default 3).
- R6: A status read in any of the cycles F-5 to F-1 prevents `irq_no` from going low at the next boundary. A read in cycle F-6 or earlier does not.
- R7: A read in cycle F-5 or F-4 returns bit 7 as 0. The flag still rises in cycle F-3, and the interrupt is still suppressed.
- R8: The frame length is 71364 cycles with `ntsc_i`=0 and 59736 cycles with `ntsc_i`=1. `ntsc_i` is sampled only in the last cycle of a frame and takes effect in the frame that follows.
- R9: With `text_mode_i`=0, a write strobe in a cycle whose counter value is 27130 or more produces a one-cycle high pulse on `wr_fail_o` in the next cycle. A strobe in cycles 0 to 27129 produces none.
- R10: With `text_mode_i`=1, `wr_fail_o` stays low for write strobes in every cycle of the frame.
- R11: `wr_fail_o` is high only in the cycle after a write strobe. With no strobe it stays low, even inside the failing window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock, one count per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ntsc_i | input | 1 | Frame length select: 0 for 50 Hz, 1 for 60 Hz |
| text_mode_i | input | 1 | Text mode; disables the write-loss window |
| stat_rd_i | input | 1 | Status port read strobe, one per read cycle |
| vram_wr_i | input | 1 | Full-speed video memory write strobe |
| stat_o | output | 8 | Status value; bit 7 is the frame flag |
| irq_no | output | 1 | Frame interrupt, active low |
| wr_fail_o | output | 1 | Pulse: the previous cycle's write would be lost |

## Verification
If the counter is off by even one count, it shows at once in three places. The flag edge moves off cycle F-3, the interrupt moves off the boundary, and the write-loss edge moves off its threshold. All three can be seen within a single frame. A stuck suppress or acknowledge state shows as an interrupt that appears, or is missing, at the next boundary. A wrong latency count shows as the line releasing in a cycle other than t+3. The sweeps therefore move the read cycle across every position near the boundary and put a write on nearly every cycle of a frame, in both modes.

// File: rtl/frame_irq_pkg.sv
package frame_irq_pkg;
  // width able to hold values 0..n
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/frame_irq_cnt.sv
module frame_irq_cnt #(
  parameter int unsigned PAL_CYC  = 71364,
  parameter int unsigned NTSC_CYC = 59736,
  parameter int unsigned CW       = 17
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ntsc_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] len_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q, len_q;

  assign wrap_o = (cnt_q == len_q - CW'(1));
  assign cnt_o  = cnt_q;
  assign len_o  = len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      len_q <= CW'(PAL_CYC);
    end else if (wrap_o) begin
      cnt_q <= '0;
      len_q <= ntsc_i ? CW'(NTSC_CYC) : CW'(PAL_CYC);
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/frame_irq_stat.sv
module frame_irq_stat #(
  parameter int unsigned CW        = 17,
  parameter int unsigned FLAG_LEAD = 3,
  parameter int unsigned ACK_LEAD  = 5,
  parameter int unsigned ACK_LAT   = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] len_i,
  input  logic          wrap_i,
  input  logic          rd_i,
  output logic          flag_o,
  output logic          irq_no
);
  localparam int unsigned AW = frame_irq_pkg::cnt_width(ACK_LAT);

  logic          flag_q, flag_d;
  logic          sup_q, sup_d;
  logic          irq_q, irq_d;
  logic [AW-1:0] ack_q, ack_d;
  logic          flag_set, in_win, late_rd, irq_set, irq_clr;

  assign flag_set = (cnt_i == len_i - CW'(FLAG_LEAD + 1));
  assign in_win   = (cnt_i >= len_i - CW'(ACK_LEAD));
  assign late_rd  = rd_i & in_win;
  assign irq_set  = wrap_i & ~sup_q & ~late_rd;

  always_comb begin
    // rising edge of the flag wins over a same-cycle clear
    flag_d = flag_set ? 1'b1 : (rd_i ? 1'b0 : flag_q);
    sup_d  = wrap_i ? 1'b0 : (late_rd ? 1'b1 : sup_q);
    ack_d   = ack_q;
    irq_clr = 1'b0;
    if (ack_q != '0) begin
      ack_d   = ack_q - AW'(1);
      irq_clr = (ack_q == AW'(1));
    end else if (rd_i && irq_q) begin
      if (ACK_LAT <= 1) irq_clr = 1'b1;
      else              ack_d   = AW'(ACK_LAT - 1);
    end
    irq_d = irq_set ? 1'b1 : (irq_clr ? 1'b0 : irq_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      sup_q  <= 1'b0;
      irq_q  <= 1'b0;
      ack_q  <= '0;
    end else begin
      flag_q <= flag_d;
      sup_q  <= sup_d;
      irq_q  <= irq_d;
      ack_q  <= ack_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_no = ~irq_q;
endmodule

// File: rtl/frame_irq_wr.sv
module frame_irq_wr #(
  parameter int unsigned CW         = 17,
  parameter int unsigned FAST_LIMIT = 27130
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic          wr_i,
  input  logic          text_i,
  output logic          fail_o
);
  logic fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fail_q <= 1'b0;
    else         fail_q <= wr_i & ~text_i & (cnt_i >= CW'(FAST_LIMIT));
  end

  assign fail_o = fail_q;
endmodule

// File: rtl/frame_irq.sv
module frame_irq #(
  parameter int unsigned PAL_CYC    = 71364,
  parameter int unsigned NTSC_CYC   = 59736,
  parameter int unsigned FLAG_LEAD  = 3,
  parameter int unsigned ACK_LEAD   = 5,
  parameter int unsigned ACK_LAT    = 3,
  parameter int unsigned FAST_LIMIT = 27130
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ntsc_i,
  input  logic       text_mode_i,
  input  logic       stat_rd_i,
  input  logic       vram_wr_i,
  output logic [7:0] stat_o,
  output logic       irq_no,
  output logic       wr_fail_o
);
  localparam int unsigned CW = frame_irq_pkg::cnt_width(PAL_CYC);

  logic [CW-1:0] cnt, len;
  logic          wrap, flag;

  frame_irq_cnt #(.PAL_CYC(PAL_CYC), .NTSC_CYC(NTSC_CYC), .CW(CW)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ntsc_i(ntsc_i),
    .cnt_o (cnt),
    .len_o (len),
    .wrap_o(wrap)
  );

  frame_irq_stat #(
    .CW(CW), .FLAG_LEAD(FLAG_LEAD), .ACK_LEAD(ACK_LEAD), .ACK_LAT(ACK_LAT)
  ) u_stat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_i (cnt),
    .len_i (len),
    .wrap_i(wrap),
    .rd_i  (stat_rd_i),
    .flag_o(flag),
    .irq_no(irq_no)
  );

  frame_irq_wr #(.CW(CW), .FAST_LIMIT(FAST_LIMIT)) u_wr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_i (cnt),
    .wr_i  (vram_wr_i),
    .text_i(text_mode_i),
    .fail_o(wr_fail_o)
  );

  assign stat_o = {flag, 7'b0};
endmodule

// File: rtl/frame_irq_chk.sv
module frame_irq_chk #(
  parameter int unsigned CW        = 17,
  parameter int unsigned FLAG_LEAD = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          text_mode_i,
  input logic          stat_rd_i,
  input logic          vram_wr_i,
  input logic [7:0]    stat_o,
  input logic          irq_no,
  input logic          wr_fail_o,
  input logic [CW-1:0] cnt_i,
  input logic [CW-1:0] len_i,
  input logic          wrap_i
);
  a_r2_flag_rise_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[7]) |-> (cnt_i == len_i - CW'(FLAG_LEAD)));

  a_r2_low_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[6:0] == 7'b0);

  a_r3_irq_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_no) |-> (cnt_i == '0));

  a_r3_flag_before_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_no) |-> $past(stat_o[7]));

  a_r4_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && cnt_i != len_i - CW'(FLAG_LEAD + 1)) |=> !stat_o[7]);

  a_r6_last_read_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && wrap_i && irq_no) |=> irq_no);

  a_r9_fail_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fail_o |-> ($past(vram_wr_i) && !$past(text_mode_i)));
endmodule

bind frame_irq frame_irq_chk #(.CW(CW), .FLAG_LEAD(FLAG_LEAD)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .text_mode_i(text_mode_i),
  .stat_rd_i  (stat_rd_i),
  .vram_wr_i  (vram_wr_i),
  .stat_o     (stat_o),
  .irq_no     (irq_no),
  .wr_fail_o  (wr_fail_o),
  .cnt_i      (cnt),
  .len_i      (len),
  .wrap_i     (wrap)
);

// File: tb/frame_irq_tb.sv
`timescale 1ns/100ps
module frame_irq_tb;
  localparam int F  = 40;
  localparam int N  = 32;
  localparam int LIM = 20;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ntsc_i = 1'b0, text_mode_i = 1'b0, stat_rd_i = 1'b0, vram_wr_i = 1'b0;
  logic [7:0] stat_o;
  logic irq_no, wr_fail_o;

  int vec = 0, err = 0, k = 0, s_k = 0;
  logic [7:0] s_stat;
  logic s_irq, s_fail;

  always #2.5 clk = ~clk;

  frame_irq #(.PAL_CYC(F), .NTSC_CYC(N), .FLAG_LEAD(3), .ACK_LEAD(5),
              .ACK_LAT(3), .FAST_LIMIT(LIM)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ntsc_i(ntsc_i), .text_mode_i(text_mode_i),
    .stat_rd_i(stat_rd_i), .vram_wr_i(vram_wr_i),
    .stat_o(stat_o), .irq_no(irq_no), .wr_fail_o(wr_fail_o)
  );

  task automatic check(input string req, input int act, input int exp);
    vec++;
    if (act != exp) begin
      err++;
      $display("FAIL %s cycle %0d: got %0d expected %0d", req, s_k, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; stat_rd_i = 1'b0; vram_wr_i = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_ni = 1'b1;
    k = 0;
  endtask

  // run one cycle with given strobes; capture outputs of that cycle
  task automatic tick(input logic rd, input logic wr);
    stat_rd_i = rd; vram_wr_i = wr;
    @(negedge clk);
    s_k = k; s_stat = stat_o; s_irq = irq_no; s_fail = wr_fail_o;
    @(posedge clk);
    #1 k++;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    err++; vec++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, err);
    $finish;
  end

  initial begin
    // R1 reset state, R2/R3 first frame, R4/R5 acknowledge
    do_reset();
    for (int i = 0; i <= F + 9; i++) begin
      tick(k == F + 6, 1'b0);
      if (s_k == 0) begin
        check("R1 stat", s_stat, 0); check("R1 irq_no", s_irq, 1); check("R1 wr_fail", s_fail, 0);
      end
      if (s_k == F - 4) check("R2 flag before", s_stat, 8'h00);
      if (s_k == F - 3) check("R2 flag rises", s_stat, 8'h80);
      if (s_k == F - 1) check("R3 irq before boundary", s_irq, 1);
      if (s_k == F)     check("R3 irq at boundary", s_irq, 0);
      if (s_k == F + 5) check("R3 irq held", s_irq, 0);
      if (s_k == F + 6) check("R4 read value", s_stat, 8'h80);
      if (s_k == F + 7) begin check("R4 flag cleared", s_stat, 0); check("R5 irq t+1", s_irq, 0); end
      if (s_k == F + 8) check("R5 irq t+2", s_irq, 0);
      if (s_k == F + 9) check("R5 irq t+3", s_irq, 1);
    end

    // R6/R7 sweep of read position before the boundary
    for (int d = 1; d <= 8; d++) begin
      do_reset();
      for (int i = 0; i <= F; i++) begin
        tick(k == F - d, 1'b0);
        if (s_k == F - d) check(d <= 3 ? "R4 read in flag" : "R7 read before flag",
                                s_stat, d <= 3 ? 8'h80 : 8'h00);
        if (s_k == F) begin
          check(d >= 4 ? "R7 flag still rises" : "R4 flag cleared", s_stat, d >= 4 ? 8'h80 : 8'h00);
          check(d <= 5 ? "R6 irq suppressed" : "R6 irq not suppressed", s_irq, d <= 5 ? 1 : 0);
        end
      end
    end

    // R8 standard select takes effect at the boundary; reset starts 50 Hz
    do_reset();
    ntsc_i = 1'b1;
    for (int i = 0; i <= F + N; i++) begin
      tick(k == F + 5, 1'b0);
      if (s_k == F - 1) check("R8 irq pre first", s_irq, 1);
      if (s_k == F)     check("R8 first boundary long frame", s_irq, 0);
      if (s_k == F + 8) check("R5 ack release", s_irq, 1);
      if (s_k == F + N - 4) check("R8 flag early", s_stat, 0);
      if (s_k == F + N - 3) check("R8 flag short frame", s_stat, 8'h80);
      if (s_k == F + N - 1) check("R8 irq pre second", s_irq, 1);
      if (s_k == F + N)     check("R8 second boundary short frame", s_irq, 0);
    end
    ntsc_i = 1'b0;

    // R9/R11 graphics-mode write sweep
    do_reset();
    text_mode_i = 1'b0;
    begin
      logic prev = 1'b0;
      for (int i = 0; i <= F + 4; i++) begin
        logic w = (i % 3) != 2;
        tick(1'b0, w);
        if (prev) check("R9 write window", s_fail, ((i - 1) % F) >= LIM);
        else      check("R11 no strobe", s_fail, 0);
        prev = w;
      end
    end

    // R10 text mode never fails
    do_reset();
    text_mode_i = 1'b1;
    for (int i = 0; i <= F + 2; i++) begin
      tick(1'b0, 1'b1);
      check("R10 text mode", s_fail, 0);
    end
    text_mode_i = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", vec, err);
    $finish;
  end
endmodule